// File: doc/BRIEF.md
# Packed Calendar Counter with Alarm

This block keeps wall-clock time as a calendar rather than as a seconds count. Seconds, minutes, hours, weekday, day of month and month sit together in one packed 32-bit time word. The year is held in a separate 16-bit BCD word, with the century in its upper byte. A once-per-second tick, derived elsewhere from the 32.768 kHz oscillator, advances the calendar only while the run bit is set. Each advance carries through every field, follows Gregorian month lengths and leap years, and increments the year in BCD.

Software sets the time with a two-step write. It first writes the year load register, which only stages the value. The following time load write sets the time word and, in the same cycle, copies the staged year into the counter. Two match registers hold a full alarm time and year. The weekday cannot be masked, so every field takes part in the comparison. When a tick moves the counter onto exactly the programmed time and year, the block raises a one-cycle alarm pulse for the interrupt logic.

Top module: `cal_counter`

## Requirements
- R1: After reset the time word reads 0x02120000 (00:00:00, weekday 1, day 1, month 1), the year reads 0x2000, the run bit is clear, the staged year is 0x2000, both match registers are zero and the alarm output is low.
- R2: Time word fields: seconds in bits 5:0 (0..59), minutes in bits 11:6 (0..59), hours in bits 16:12 (0..23), weekday in bits 19:17 (1..7, 1 = Sunday), day of month in bits 24:20 (1..31) and month in bits 28:25 (1..12, 1 = January). Bits 31:29 read zero. A counted tick increments seconds. Seconds wrap 59 to 0 and carry into minutes, and minutes wrap 59 to 0 and carry into hours.
- R3: When hours wrap from 23 to 0, the day of month advances and the weekday advances, wrapping from 7 to 1.
- R4: A month has 30 days for months 4, 6, 9 and 11 and 31 days for the other months except February. After its last day the day returns to 1 and the month advances.
- R5: February has 29 days when the year is a leap year and 28 otherwise. A year is a leap year when its two BCD year digits are a multiple of four and nonzero, or when they are 00 and the BCD century is a multiple of four.
- R6: Year word: bits 7:0 hold two BCD year digits and bits 15:8 hold two BCD century digits. On 31 December at 23:59:59 a tick gives 1 January 00:00:00. The year then increments in BCD, carrying into the century when the year digits roll from 99 to 00, and 9999 wraps to 0000.
- R7: Ticks advance the calendar only while run bit 26 of the control register at offset 0x0C is set. With the bit clear, a tick leaves both words unchanged.
- R8: A write to the year load register at 0x38 only stages the year and leaves the year output unchanged. A write to the time load register at 0x08 takes effect on the next edge and also copies the staged year into the year word.
- R9: Matches are written at 0x04 (time) and 0x34 (year). The alarm is high for exactly one cycle, the cycle after a counted tick whose result equals both match registers in every field including the weekday. No alarm occurs if any field or the year differs.
- R10: When a time load write and a counted tick fall in the same cycle, the load wins, the tick is discarded and no alarm is raised.
- R11: Writes to any offset other than 0x04, 0x08, 0x0C, 0x34 and 0x38 have no effect, including the read offsets 0x00 and 0x30. Load data bits 31:29 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Byte offset of the write |
| wr_data | input | 32 | Write data |
| time_q | output | 32 | Current packed time word |
| year_q | output | 16 | Current BCD year word |
| alarm | output | 1 | One-cycle alarm pulse |

## Verification
The two functions that can fall in the same cycle are the software time load and the counted tick. The two-step load sequence and the alarm check depend on which of them takes the cycle. The bench parks the counter one second before a programmed match. It then issues a time load in the same cycle as a tick. It judges the result by checking that the time word holds the loaded value rather than the advanced one, that the year comes from the staging register, and that the alarm stays low even though the discarded tick would have matched.

// File: rtl/cal_counter.sv
module cal_counter #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   time_q,
  output logic [15:0]   year_q,
  output logic          alarm
);
  localparam logic [AW-1:0] OFS_MATCH  = AW'('h04);
  localparam logic [AW-1:0] OFS_LOAD   = AW'('h08);
  localparam logic [AW-1:0] OFS_CTRL   = AW'('h0C);
  localparam logic [AW-1:0] OFS_YMATCH = AW'('h34);
  localparam logic [AW-1:0] OFS_YLOAD  = AW'('h38);
  localparam int            RUN_BIT    = 26;
  localparam logic [28:0]   T_RESET    = 29'h0212_0000;
  localparam logic [15:0]   Y_RESET    = 16'h2000;

  logic [28:0] t, mt, nt;
  logic [15:0] y, my, ys, ny;
  logic        run;

  logic [5:0] sec, mins;
  logic [4:0] hr, dom, mlen;
  logic [2:0] wd;
  logic [3:0] mon;
  assign {mon, dom, wd, hr, mins, sec} = t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {(v[7:4] == 4'd9) ? 4'd0 : v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic div4(input logic [7:0] v);
    return v[4] ? (v[3:0] == 4'd2 || v[3:0] == 4'd6)
                : (v[3:0] == 4'd0 || v[3:0] == 4'd4 || v[3:0] == 4'd8);
  endfunction

  logic leap;
  assign leap = (y[7:0] == 8'h00) ? div4(y[15:8]) : div4(y[7:0]);

  always_comb begin
    case (mon)
      4'd2:                      mlen = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   mlen = 5'd30;
      default:                   mlen = 5'd31;
    endcase
  end

  logic c_min, c_hr, c_day, c_mon, c_yr;
  assign c_min = sec == 6'd59;
  assign c_hr  = c_min && mins == 6'd59;
  assign c_day = c_hr && hr == 5'd23;
  assign c_mon = c_day && dom == mlen;
  assign c_yr  = c_mon && mon == 4'd12;

  assign nt = { c_mon ? (c_yr ? 4'd1 : mon + 4'd1) : mon,
                c_day ? (c_mon ? 5'd1 : dom + 5'd1) : dom,
                c_day ? ((wd == 3'd7) ? 3'd1 : wd + 3'd1) : wd,
                c_hr  ? (c_day ? 5'd0 : hr + 5'd1) : hr,
                c_min ? (c_hr ? 6'd0 : mins + 6'd1) : mins,
                c_min ? 6'd0 : sec + 6'd1 };

  assign ny = !c_yr ? y : {(y[7:0] == 8'h99) ? bcd_inc(y[15:8]) : y[15:8], bcd_inc(y[7:0])};

  logic ld;
  assign ld = wr_en && wr_addr == OFS_LOAD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t     <= T_RESET;
      y     <= Y_RESET;
      ys    <= Y_RESET;
      mt    <= '0;
      my    <= '0;
      run   <= 1'b0;
      alarm <= 1'b0;
    end else begin
      alarm <= 1'b0;
      if (ld) begin
        t <= wr_data[28:0];
        y <= ys;
      end else if (run && tick) begin
        t     <= nt;
        y     <= ny;
        alarm <= (nt == mt) && (ny == my);
      end
      if (wr_en) begin
        case (wr_addr)
          OFS_MATCH:  mt  <= wr_data[28:0];
          OFS_CTRL:   run <= wr_data[RUN_BIT];
          OFS_YMATCH: my  <= wr_data[15:0];
          OFS_YLOAD:  ys  <= wr_data[15:0];
          default: ;
        endcase
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^wr_data[31:29];

  assign time_q = {3'b000, t};
  assign year_q = y;

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (time_q == {3'b000, $past(wr_data[28:0])}) && (year_q == $past(ys)));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(time_q) && $stable(year_q));

  assert_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> (t == $past(mt)) && (y == $past(my)));

  assert_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> $past(run && tick && !ld));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> !alarm);

  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && tick) |=> !alarm);
endmodule

// File: tb/sim_cal_counter.sv
`timescale 1ns/1ps
module sim_cal_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] time_q;
  logic [15:0] year_q;
  logic        alarm;

  always #2.5 clk = ~clk;

  cal_counter #(.AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .time_q(time_q), .year_q(year_q), .alarm(alarm)
  );

  typedef struct {
    logic [31:0] t;
    logic [15:0] y;
    logic        a;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [31:0] pk(int mo, int dd, int wd, int hh, int mm, int ss);
    return 32'((mo << 25) | (dd << 20) | (wd << 17) | (hh << 12) | (mm << 6) | ss);
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (time_q !== it.t || year_q !== it.y || alarm !== it.a) begin
        errors++;
        $display("FAIL %s time %h exp %h year %h exp %h alarm %b exp %b",
                 it.tag, time_q, it.t, year_q, it.y, alarm, it.a);
      end
    end
  end

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk,
                     input logic chk, input logic [31:0] et, input logic [15:0] ey,
                     input logic ea, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    @(posedge clk);
    if (chk) q.push_back('{et, ey, ea, tag});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, '0, '0, 1'b0, "");
  endtask

  task automatic scen(input logic [15:0] yr, input logic [31:0] t0, input logic [31:0] t1,
                      input logic [15:0] y1, input logic ea, input string tag);
    wr(8'h38, 32'(yr));
    cyc(1'b1, 8'h08, t0, 1'b0, 1'b1, t0, yr, 1'b0, tag);
    cyc(1'b0, 8'h00, '0, 1'b1, 1'b1, t1, y1, ea, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    cyc(0, 8'h00, '0, 0, 1, 32'h0212_0000, 16'h2000, 0, "R1");
    // R7 tick ignored while stopped
    cyc(0, 8'h00, '0, 1, 1, 32'h0212_0000, 16'h2000, 0, "R7");
    // R8 staged year does not show until time load
    cyc(1, 8'h38, 32'h2024, 0, 1, 32'h0212_0000, 16'h2000, 0, "R8");
    cyc(1, 8'h08, pk(6,15,3,12,34,56), 0, 1, pk(6,15,3,12,34,56), 16'h2024, 0, "R8");
    cyc(0, 8'h00, '0, 1, 1, pk(6,15,3,12,34,56), 16'h2024, 0, "R7");
    wr(8'h0C, 32'h0400_0000);
    cyc(0, 8'h00, '0, 1, 1, pk(6,15,3,12,34,57), 16'h2024, 0, "R2");
    scen(16'h2024, pk(6,15,3,10,59,59), pk(6,15,3,11,0,0), 16'h2024, 0, "R2");
    scen(16'h2024, pk(6,15,3,10,5,59), pk(6,15,3,10,6,0), 16'h2024, 0, "R2");
    scen(16'h2024, pk(1,10,7,23,59,59), pk(1,11,1,0,0,0), 16'h2024, 0, "R3");
    scen(16'h2024, pk(4,30,2,23,59,59), pk(5,1,3,0,0,0), 16'h2024, 0, "R4");
    scen(16'h2024, pk(1,30,5,23,59,59), pk(1,31,6,0,0,0), 16'h2024, 0, "R4");
    scen(16'h2024, pk(11,30,1,23,59,59), pk(12,1,2,0,0,0), 16'h2024, 0, "R4");
    scen(16'h2024, pk(2,28,4,23,59,59), pk(2,29,5,0,0,0), 16'h2024, 0, "R5");
    scen(16'h2024, pk(2,29,5,23,59,59), pk(3,1,6,0,0,0), 16'h2024, 0, "R5");
    scen(16'h2023, pk(2,28,3,23,59,59), pk(3,1,4,0,0,0), 16'h2023, 0, "R5");
    scen(16'h2100, pk(2,28,1,23,59,59), pk(3,1,2,0,0,0), 16'h2100, 0, "R5");
    scen(16'h2000, pk(2,28,2,23,59,59), pk(2,29,3,0,0,0), 16'h2000, 0, "R5");
    scen(16'h2012, pk(2,28,3,23,59,59), pk(2,29,4,0,0,0), 16'h2012, 0, "R5");
    scen(16'h2099, pk(12,31,5,23,59,59), pk(1,1,6,0,0,0), 16'h2100, 0, "R6");
    scen(16'h2019, pk(12,31,3,23,59,59), pk(1,1,4,0,0,0), 16'h2020, 0, "R6");
    scen(16'h9999, pk(12,31,7,23,59,59), pk(1,1,1,0,0,0), 16'h0000, 0, "R6");
    // R9 alarm on exact match
    wr(8'h04, pk(7,4,2,8,0,0));
    wr(8'h34, 32'h2025);
    scen(16'h2025, pk(7,4,2,7,59,59), pk(7,4,2,8,0,0), 16'h2025, 1, "R9");
    cyc(0, 8'h00, '0, 0, 1, pk(7,4,2,8,0,0), 16'h2025, 0, "R9");
    scen(16'h2025, pk(7,4,3,7,59,59), pk(7,4,3,8,0,0), 16'h2025, 0, "R9");
    scen(16'h2026, pk(7,4,2,7,59,59), pk(7,4,2,8,0,0), 16'h2026, 0, "R9");
    // R10 load and tick in the same cycle
    wr(8'h38, 32'h2025);
    cyc(1, 8'h08, pk(7,4,2,7,59,59), 0, 1, pk(7,4,2,7,59,59), 16'h2025, 0, "R10");
    cyc(1, 8'h08, pk(3,3,3,3,3,3), 1, 1, pk(3,3,3,3,3,3), 16'h2025, 0, "R10");
    // R11 ignored offsets and dropped top bits
    cyc(1, 8'h00, 32'hFFFF_FFFF, 0, 1, pk(3,3,3,3,3,3), 16'h2025, 0, "R11");
    cyc(1, 8'h30, 32'h0000_FFFF, 0, 1, pk(3,3,3,3,3,3), 16'h2025, 0, "R11");
    cyc(1, 8'h08, pk(3,3,3,3,3,4) | 32'hE000_0000, 0, 1, pk(3,3,3,3,3,4), 16'h2025, 0, "R11");
    // R7 stop again
    wr(8'h0C, 32'h0000_0000);
    cyc(0, 8'h00, '0, 1, 1, pk(3,3,3,3,3,4), 16'h2025, 0, "R7");
    cyc(0, 8'h00, '0, 0, 0, '0, '0, 0, "");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule